// File: doc/BRIEF.md
# Submodule Capacitor Voltage Protection Monitor

This block watches the capacitor voltage of one converter submodule and takes the submodule out of service when that voltage leaves its allowed band. The voltage arrives as an unsigned per-unit fixed-point word with 12 fractional bits, so 1.0 pu is 0x1000. Three independent checks run in parallel. Two are overvoltage levels, each with its own threshold, and one is an undervoltage check. Each check has an enable and an auto-recovery option. A tripped check with auto-recovery set releases itself once the voltage is back inside its threshold. A tripped check without that option stays tripped until a synchronous clear or a reset.

While any check is tripped, the monitor is in bypass. The bypass output is high, the held capacitor voltage is frozen, and the submodule output voltage request is forced to zero. The block also assembles a 16-bit state word. This word combines the externally supplied gate fault flags, the breaker and capacitor short flags, the deactivated status and the three trip flags.

Each check is a two-state machine: CH_ARMED and CH_TRIPPED. The arm-to-trip transition fires when the check is enabled and its comparison is violated. The trip-to-arm transition fires on clear, or on auto-recovery with the voltage inside the threshold. Clear has priority over a new trip. The monitor itself is a two-state machine, MON_NORMAL and MON_BYPASS. It enters MON_BYPASS on the edge where any check enters or stays in CH_TRIPPED, and it returns to MON_NORMAL on the edge where none does.

Top module: `sm_vprot_monitor`

## Requirements
- R1: With the level-1 overvoltage check enabled and the voltage strictly greater than its threshold at a clock edge, state word bit 10 and bypass are high after that edge. A voltage equal to the threshold does not trip.
- R2: The level-2 overvoltage check behaves like R1 with its own threshold, enable and option, reports in state word bit 11, and is independent of level 1.
- R3: With the undervoltage check enabled and the voltage strictly below its threshold at a clock edge, state word bit 12 and bypass are high after that edge. A voltage equal to the threshold does not trip.
- R4: While bypass is high, the output voltage request is zero and the held voltage stays at the value sampled on the tripping edge. While bypass is low, the output request follows its input.
- R5: A tripped check whose auto-recovery option is clear stays tripped when the voltage returns inside the threshold.
- R6: A tripped check whose auto-recovery option is set returns to armed on the first edge at which the voltage is inside the threshold, where equality counts as inside, and its state bit and bypass drop after that edge.
- R7: A clear held high at an edge returns every tripped check to armed, even while a violation is present. If the violation persists, the check trips again on the next edge.
- R8: A disabled check never trips, whatever the voltage.
- R9: Thresholds above 4.0 pu (0x4000) act as 4.0 pu.
- R10: State word layout: bits 0 to 7 = gate fault flags {G4 short, G4 open, ..., G1 short, G1 open}, so bit 0 is G1 open and bit 1 is G1 short. Bit 8 = breaker closed, bit 9 = submodule deactivated (equal to bypass), bits 10, 11 and 12 = level-1 overvoltage, level-2 overvoltage and undervoltage tripped, bit 13 = capacitor short, bits 14 and 15 = 0.
- R11: During and right after reset all checks are armed, bypass is low, the held voltage is 0 and the trip bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all tripped checks |
| vcap_i | input | 16 | Capacitor voltage, per-unit with 12 fractional bits |
| ov1_thr_i | input | 16 | Level-1 overvoltage threshold |
| ov1_en_i | input | 1 | Level-1 overvoltage enable |
| ov1_auto_i | input | 1 | Level-1 auto-recovery option |
| ov2_thr_i | input | 16 | Level-2 overvoltage threshold |
| ov2_en_i | input | 1 | Level-2 overvoltage enable |
| ov2_auto_i | input | 1 | Level-2 auto-recovery option |
| uv_thr_i | input | 16 | Undervoltage threshold |
| uv_en_i | input | 1 | Undervoltage enable |
| uv_auto_i | input | 1 | Undervoltage auto-recovery option |
| gate_flt_i | input | 8 | Gate fault flags, open/short per gate G1..G4 |
| brk_closed_i | input | 1 | Breaker closed flag |
| cap_short_i | input | 1 | Capacitor short-circuit flag |
| vout_req_i | input | 16 | Submodule output voltage request |
| vout_o | output | 16 | Output request, zero during bypass |
| bypass_o | output | 1 | Submodule bypass |
| vcap_hold_o | output | 16 | Held capacitor voltage |
| state_o | output | 16 | Submodule state word |

## Verification
The bench builds the block with its defaults: a 16-bit voltage with 12 fractional bits and a 4 pu ceiling. With these values the 0x4000 clamp can be tested directly by writing a threshold of 0xFFFF and stepping the voltage from 0x4000 to 0x4001. The thresholds are placed at 1.2, 1.5 and 0.5 pu, so each strict comparison can be probed one code on either side of its threshold, and one check can be driven into violation while another stays disabled. Auto-recovery is tested at exact threshold equality, and clear is tested while a violation persists, so the re-trip on the following edge is observable.

// File: rtl/sm_vprot_pkg.sv
package sm_vprot_pkg;
    typedef enum logic {CH_ARMED, CH_TRIPPED} ch_state_e;
    typedef enum logic {MON_NORMAL, MON_BYPASS} mon_state_e;

    localparam int NUM_CHK  = 3;
    localparam int CHK_OV1  = 0;
    localparam int CHK_OV2  = 1;
    localparam int CHK_UV   = 2;
    localparam int NUM_GATE = 4;
    localparam int WORD_W   = 16;
endpackage

// File: rtl/sm_vprot_chan.sv
module sm_vprot_chan
    import sm_vprot_pkg::*;
#(
    parameter int VW       = 16,
    parameter int FRAC     = 12,
    parameter int MAX_PU   = 4,
    parameter bit IS_UNDER = 1'b0
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          en_i,
    input  logic          auto_i,
    input  logic [VW-1:0] thr_i,
    input  logic [VW-1:0] vcap_i,
    output logic          tripped_o,
    output logic          trip_next_o
);
    localparam logic [VW-1:0] TH_MAX = VW'(MAX_PU << FRAC);

    ch_state_e     state_q, state_d;
    logic [VW-1:0] thr_eff;
    logic          viol;

    assign thr_eff = (thr_i > TH_MAX) ? TH_MAX : thr_i;

    generate
        if (IS_UNDER) begin : g_under
            assign viol = (vcap_i < thr_eff);
        end else begin : g_over
            assign viol = (vcap_i > thr_eff);
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= CH_ARMED;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_ARMED: begin
                if (!clr_i && en_i && viol) state_d = CH_TRIPPED;
            end
            CH_TRIPPED: begin
                if (clr_i || (auto_i && !viol)) state_d = CH_ARMED;
            end
            default: state_d = CH_ARMED;
        endcase
    end

    assign tripped_o   = (state_q == CH_TRIPPED);
    assign trip_next_o = (state_d == CH_TRIPPED);
endmodule

// File: rtl/sm_vprot_word.sv
module sm_vprot_word
    import sm_vprot_pkg::*;
(
    input  logic [2*NUM_GATE-1:0] gate_flt_i,
    input  logic                  brk_closed_i,
    input  logic                  deact_i,
    input  logic [NUM_CHK-1:0]    trip_i,
    input  logic                  cap_short_i,
    output logic [WORD_W-1:0]     word_o
);
    always_comb begin
        word_o                  = '0;
        word_o[2*NUM_GATE-1:0]  = gate_flt_i;
        word_o[8]               = brk_closed_i;
        word_o[9]               = deact_i;
        word_o[10]              = trip_i[CHK_OV1];
        word_o[11]              = trip_i[CHK_OV2];
        word_o[12]              = trip_i[CHK_UV];
        word_o[13]              = cap_short_i;
    end
endmodule

// File: rtl/sm_vprot_monitor.sv
module sm_vprot_monitor
    import sm_vprot_pkg::*;
#(
    parameter int VW     = 16,
    parameter int FRAC   = 12,
    parameter int MAX_PU = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  clr_i,
    input  logic [VW-1:0]         vcap_i,
    input  logic [VW-1:0]         ov1_thr_i,
    input  logic                  ov1_en_i,
    input  logic                  ov1_auto_i,
    input  logic [VW-1:0]         ov2_thr_i,
    input  logic                  ov2_en_i,
    input  logic                  ov2_auto_i,
    input  logic [VW-1:0]         uv_thr_i,
    input  logic                  uv_en_i,
    input  logic                  uv_auto_i,
    input  logic [2*NUM_GATE-1:0] gate_flt_i,
    input  logic                  brk_closed_i,
    input  logic                  cap_short_i,
    input  logic [VW-1:0]         vout_req_i,
    output logic [VW-1:0]         vout_o,
    output logic                  bypass_o,
    output logic [VW-1:0]         vcap_hold_o,
    output logic [WORD_W-1:0]     state_o
);
    logic [VW-1:0]      thr_a  [NUM_CHK];
    logic [NUM_CHK-1:0] en_a, auto_a, trip_q, trip_d;
    mon_state_e         mon_q, mon_d;
    logic [VW-1:0]      hold_q;

    assign thr_a[CHK_OV1] = ov1_thr_i;
    assign thr_a[CHK_OV2] = ov2_thr_i;
    assign thr_a[CHK_UV]  = uv_thr_i;
    assign en_a   = {uv_en_i, ov2_en_i, ov1_en_i};
    assign auto_a = {uv_auto_i, ov2_auto_i, ov1_auto_i};

    for (genvar g = 0; g < NUM_CHK; g++) begin : g_chk
        sm_vprot_chan #(
            .VW       (VW),
            .FRAC     (FRAC),
            .MAX_PU   (MAX_PU),
            .IS_UNDER (g == CHK_UV)
        ) u_chan (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .clr_i       (clr_i),
            .en_i        (en_a[g]),
            .auto_i      (auto_a[g]),
            .thr_i       (thr_a[g]),
            .vcap_i      (vcap_i),
            .tripped_o   (trip_q[g]),
            .trip_next_o (trip_d[g])
        );
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mon_q <= MON_NORMAL;
        else         mon_q <= mon_d;
    end

    always_comb begin
        mon_d = mon_q;
        unique case (mon_q)
            MON_NORMAL: if (|trip_d)  mon_d = MON_BYPASS;
            MON_BYPASS: if (!(|trip_d)) mon_d = MON_NORMAL;
            default:    mon_d = MON_NORMAL;
        endcase
    end

    // held voltage tracks the input until bypass freezes it
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 hold_q <= '0;
        else if (mon_q == MON_NORMAL) hold_q <= vcap_i;
    end

    // outputs
    always_comb begin
        bypass_o    = 1'b0;
        vout_o      = vout_req_i;
        unique case (mon_q)
            MON_NORMAL: ;
            MON_BYPASS: begin
                bypass_o = 1'b1;
                vout_o   = '0;
            end
            default: ;
        endcase
        vcap_hold_o = hold_q;
    end

    sm_vprot_word u_word (
        .gate_flt_i   (gate_flt_i),
        .brk_closed_i (brk_closed_i),
        .deact_i      (bypass_o),
        .trip_i       (trip_q),
        .cap_short_i  (cap_short_i),
        .word_o       (state_o)
    );
endmodule

// File: rtl/sm_vprot_checker.sv
module sm_vprot_checker #(
    parameter int VW     = 16,
    parameter int FRAC   = 12,
    parameter int MAX_PU = 4
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          clr_i,
    input logic [VW-1:0] vcap_i,
    input logic [VW-1:0] ov1_thr_i,
    input logic          ov1_en_i,
    input logic          ov1_auto_i,
    input logic [VW-1:0] uv_thr_i,
    input logic          uv_en_i,
    input logic [7:0]    gate_flt_i,
    input logic [VW-1:0] vout_o,
    input logic          bypass_o,
    input logic [VW-1:0] vcap_hold_o,
    input logic [15:0]   state_o
);
    localparam logic [VW-1:0] TH_MAX = VW'(MAX_PU << FRAC);

    logic past_ok;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) past_ok <= 1'b0;
        else         past_ok <= 1'b1;
    end

    p_ov1_trip_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ov1_en_i && !clr_i && ov1_thr_i <= TH_MAX && vcap_i > ov1_thr_i) |=> state_o[10]);

    p_uv_trip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (uv_en_i && !clr_i && uv_thr_i <= TH_MAX && vcap_i < uv_thr_i) |=> state_o[12]);

    p_vout_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bypass_o |-> (vout_o == '0));

    p_hold_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && bypass_o && $past(bypass_o)) |-> (vcap_hold_o == $past(vcap_hold_o)));

    p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o[10] && !ov1_auto_i && !clr_i) |=> state_o[10]);

    p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (state_o[12:10] == 3'b000));

    p_bypass_bits_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bypass_o == (|state_o[12:10])) && (state_o[9] == bypass_o));

    p_reserved_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o[15:14] == 2'b00) && (state_o[7:0] == gate_flt_i));
endmodule

bind sm_vprot_monitor sm_vprot_checker #(
    .VW     (VW),
    .FRAC   (FRAC),
    .MAX_PU (MAX_PU)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_i),
    .vcap_i      (vcap_i),
    .ov1_thr_i   (ov1_thr_i),
    .ov1_en_i    (ov1_en_i),
    .ov1_auto_i  (ov1_auto_i),
    .uv_thr_i    (uv_thr_i),
    .uv_en_i     (uv_en_i),
    .gate_flt_i  (gate_flt_i),
    .vout_o      (vout_o),
    .bypass_o    (bypass_o),
    .vcap_hold_o (vcap_hold_o),
    .state_o     (state_o)
);

// File: tb/sim_sm_vprot_monitor.sv
module sim_sm_vprot_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [15:0] vcap = '0;
    logic [15:0] ov1_thr = 16'h1333, ov2_thr = 16'h1800, uv_thr = 16'h0800;
    logic        ov1_en = 0, ov1_auto = 0, ov2_en = 0, ov2_auto = 0, uv_en = 0, uv_auto = 0;
    logic [7:0]  gflt = '0;
    logic        brk = 0, cshort = 0;
    logic [15:0] vreq = 16'h1234;
    logic [15:0] vout, vhold, sword;
    logic        byp;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sm_vprot_monitor u0 (
        .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .vcap_i(vcap),
        .ov1_thr_i(ov1_thr), .ov1_en_i(ov1_en), .ov1_auto_i(ov1_auto),
        .ov2_thr_i(ov2_thr), .ov2_en_i(ov2_en), .ov2_auto_i(ov2_auto),
        .uv_thr_i(uv_thr), .uv_en_i(uv_en), .uv_auto_i(uv_auto),
        .gate_flt_i(gflt), .brk_closed_i(brk), .cap_short_i(cshort),
        .vout_req_i(vreq), .vout_o(vout), .bypass_o(byp),
        .vcap_hold_o(vhold), .state_o(sword)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock edge, then sample at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_clear();
        clr = 1'b1; step(); clr = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11 bypass in reset", {15'd0, byp}, 16'd0);
        chk("R11 hold in reset", vhold, 16'd0);
        chk("R11 trip bits in reset", {13'd0, sword[12:10]}, 16'd0);
        rst_n = 1'b1;
        vcap = 16'h1000;
        step();
        chk("R11 bypass after reset", {15'd0, byp}, 16'd0);
        chk("R4 vout follows when normal", vout, 16'h1234);
    endtask

    task automatic t_ov1();
        ov1_en = 1; ov1_auto = 0;
        vcap = 16'h1333; step();
        chk("R1 equal no trip", {15'd0, sword[10]}, 16'd0);
        vcap = 16'h1334; step();
        chk("R1 trip bit10", {15'd0, sword[10]}, 16'd1);
        chk("R1 bypass", {15'd0, byp}, 16'd1);
        chk("R4 vout zero", vout, 16'd0);
        chk("R4 hold at trip", vhold, 16'h1334);
        vcap = 16'h1000; step();
        chk("R5 stays tripped", {15'd0, sword[10]}, 16'd1);
        chk("R4 hold frozen", vhold, 16'h1334);
        pulse_clear(); @(negedge clk);
        chk("R7 cleared", {15'd0, byp}, 16'd0);
        ov1_en = 0;
    endtask

    task automatic t_ov2();
        ov2_en = 1; ov2_auto = 1;
        vcap = 16'h1900; step();
        chk("R8 disabled ov1 silent", {15'd0, sword[10]}, 16'd0);
        chk("R2 ov2 trip bit11", {15'd0, sword[11]}, 16'd1);
        vcap = 16'h1800; step();
        chk("R6 auto recover at equality", {15'd0, sword[11]}, 16'd0);
        chk("R6 bypass released", {15'd0, byp}, 16'd0);
        ov2_en = 0; ov2_auto = 0;
    endtask

    task automatic t_uv();
        vcap = 16'h0000; step();
        chk("R8 disabled uv silent", {15'd0, byp}, 16'd0);
        uv_en = 1; uv_auto = 0;
        vcap = 16'h0800; step();
        chk("R3 equal no trip", {15'd0, sword[12]}, 16'd0);
        vcap = 16'h07FF; step();
        chk("R3 uv trip bit12", {15'd0, sword[12]}, 16'd1);
        clr = 1; step(); clr = 0;
        chk("R7 clear wins over violation", {15'd0, sword[12]}, 16'd0);
        step();
        chk("R7 retrip after clear", {15'd0, sword[12]}, 16'd1);
        vcap = 16'h1000; pulse_clear(); @(negedge clk);
        chk("R7 uv cleared", {15'd0, byp}, 16'd0);
        uv_en = 0;
    endtask

    task automatic t_clamp();
        ov1_thr = 16'hFFFF; ov1_en = 1;
        vcap = 16'h4000; step();
        chk("R9 at ceiling no trip", {15'd0, sword[10]}, 16'd0);
        vcap = 16'h4001; step();
        chk("R9 clamp trips", {15'd0, sword[10]}, 16'd1);
        vcap = 16'h1000; pulse_clear(); @(negedge clk);
        ov1_en = 0; ov1_thr = 16'h1333;
    endtask

    task automatic t_word();
        gflt = 8'hA5; brk = 1; cshort = 1; vcap = 16'h1000; step();
        chk("R10 word no trip", sword, 16'h21A5);
        uv_en = 1; vcap = 16'h0100; step();
        chk("R10 word with uv trip", sword, 16'h33A5);
        vcap = 16'h1000; pulse_clear(); @(negedge clk);
        uv_en = 0; gflt = '0; brk = 0; cshort = 0;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_ov1();
        t_ov2();
        t_uv();
        t_clamp();
        t_word();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule